// File: doc/BRIEF.md
# PCM bit-clock and frame-sync generator

This block produces the bit clock and the frame-sync strobe for a PCM voice port that runs as master. It is driven by a fast system clock, nominally 48 MHz, and takes one 32-bit configuration word. The bit clock comes from a fractional accumulator. On every system clock the accumulator adds a rate step and compares the total against a limit. Each time the total reaches or passes the limit, the limit is taken away and the bit clock toggles. The frame sync is derived by counting rising edges of the bit clock, and each frame lasts a configured multiple of eight bit clocks.

Two inputs act on the sync without touching the configuration. One chooses a high pulse of eight bit clocks (long) or one bit clock (short). The other forces the sync low while the bit clock and the frame count keep running, which a codec can use as a power-down request. A new configuration word does not take effect at once. It is held off until the running frame ends, and then both counters restart from a low bit clock. A strobe output marks each rising edge of the bit clock, so logic downstream in the same clock domain can step on bit boundaries without detecting edges itself.

Top module: `pcm_clkgen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pcm_clk`, `pcm_sync` and `bclk_rise` are 0.
- R2: The limit is `cfg_word[12:0]` and the rate is `cfg_word[23:16]`. Each cycle the accumulator adds the rate. When the total is at or above the limit, the limit is subtracted and `pcm_clk` toggles, so one bit-clock period lasts 2·limit/rate cycles on average. When the rate is at or above the limit, `pcm_clk` toggles on every cycle.
- R3: `bclk_rise` is high for exactly the one cycle in which `pcm_clk` has just changed from 0 to 1, and at no other time.
- R4: The divider is `cfg_word[31:24]`. A frame lasts divider×8 bit-clock periods. `pcm_sync` rises only together with a rising edge of `pcm_clk`, or when the force input is released.
- R5: With `sync_long`=1, `pcm_sync` stays high for the first 8 bit-clock periods of each frame.
- R6: With `sync_long`=0, `pcm_sync` stays high for the first bit-clock period of each frame only.
- R7: While `sync_force_low` is 1, `pcm_sync` is 0. `pcm_clk` keeps toggling and the frame count keeps running, so after release the sync rises again on the original frame grid.
- R8: If the active rate or the active limit is 0, `pcm_clk`, `pcm_sync` and `bclk_rise` stay at 0.
- R9: If the active divider is 0, `pcm_clk` runs but `pcm_sync` stays at 0.
- R10: A change to `cfg_word` takes effect at the next frame boundary: the rising edge that would start a new frame is dropped, and the accumulator restarts from zero with `pcm_clk` low. If the active setting is halted or has no frames, the change takes effect on the next clock.
- R11: With the word 0x08080177, the sync period is 6000 system cycles (8 kHz from 48 MHz) and the long sync pulse lasts 750 cycles. This corresponds to a 512 kHz bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (48 MHz reference) |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Limit [12:0], rate [23:16], frame divider [31:24] |
| sync_force_low | input | 1 | Holds the frame sync low while the bit clock runs on |
| sync_long | input | 1 | 1: sync high for 8 bit clocks; 0: sync high for 1 bit clock |
| pcm_clk | output | 1 | Generated bit clock |
| pcm_sync | output | 1 | Generated frame sync |
| bclk_rise | output | 1 | One-cycle strobe on each rising edge of the bit clock |

## Verification
The bench targets a rate that equals the limit, a rate larger than the limit, a fractional ratio whose bit-clock period is not a whole number of cycles, and a zero rate, zero limit and zero divider. Each of these cases exposes a specific fault. A wrong wrap compare shows up as a drift in frame length. An accumulator left unclamped changes the period when the rate exceeds the limit. A missing halt guard lets the clock run with a zero field. A configuration change that is applied at once, rather than at the frame boundary, moves the next sync rise from 99 cycles to a few cycles after the change. A force that also stopped the frame counter would bring the sync back off the original frame grid.

// File: rtl/pcm_gen_pkg.sv
package pcm_gen_pkg;

  localparam int CFG_W    = 32;
  localparam int LIM_LSB  = 0;
  localparam int LIM_W    = 13;
  localparam int RATE_LSB = 16;
  localparam int RATE_W   = 8;
  localparam int DIV_LSB  = 24;
  localparam int DIV_W    = 8;
  // one divider step is 2**UNIT_SH bit clocks
  localparam int UNIT_SH  = 3;
  localparam int FRM_W    = DIV_W + UNIT_SH;
  localparam int LONG_HI  = 8;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [RATE_W-1:0] rate;
    logic [LIM_W-1:0]  lim;
  } pcm_cfg_t;

  function automatic pcm_cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    pcm_cfg_t c;
    c.lim  = w[LIM_LSB  +: LIM_W];
    c.rate = w[RATE_LSB +: RATE_W];
    c.div  = w[DIV_LSB  +: DIV_W];
    return c;
  endfunction

  // returns {toggle, next accumulator}
  function automatic logic [LIM_W:0] acc_step(input logic [LIM_W-1:0]  acc,
                                              input logic [RATE_W-1:0] rate,
                                              input logic [LIM_W-1:0]  lim);
    logic [LIM_W:0] sum;
    logic [LIM_W:0] rem;
    sum = {1'b0, acc} + {{(LIM_W+1-RATE_W){1'b0}}, rate};
    if (sum >= {1'b0, lim}) begin
      rem = sum - {1'b0, lim};
      if (rem >= {1'b0, lim}) rem = '0;
      return {1'b1, rem[LIM_W-1:0]};
    end
    return {1'b0, sum[LIM_W-1:0]};
  endfunction

  function automatic logic [FRM_W-1:0] frame_bits(input logic [DIV_W-1:0] div);
    return {div, {UNIT_SH{1'b0}}};
  endfunction

  function automatic logic sync_on(input logic [FRM_W-1:0] pos, input logic long_sel);
    logic [FRM_W-1:0] hi;
    hi = long_sel ? FRM_W'(LONG_HI) : FRM_W'(1);
    return pos < hi;
  endfunction

endpackage

// File: rtl/pcm_cfg_hold.sv
module pcm_cfg_hold
  import pcm_gen_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             frame_end,
  output pcm_cfg_t         act,
  output logic             act_halt,
  output logic             load
);

  pcm_cfg_t req;
  pcm_cfg_t act_q;
  logic     pending;
  logic     no_frame;

  assign req      = cfg_decode(cfg_word);
  assign pending  = (req != act_q);
  assign act_halt = (act_q.rate == '0) || (act_q.lim == '0);
  assign no_frame = (act_q.div == '0);
  assign load     = pending && (act_halt || no_frame || frame_end);
  assign act      = act_q;

  always_ff @(posedge clk) begin
    if (rst)       act_q <= cfg_decode(RESET_CFG);
    else if (load) act_q <= req;
  end

endmodule

// File: rtl/pcm_bclk_acc.sv
module pcm_bclk_acc
  import pcm_gen_pkg::*;
#(
  parameter int AW = LIM_W,
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          halt,
  input  logic [RW-1:0] rate,
  input  logic [AW-1:0] lim,
  output logic          bclk,
  output logic          rise_evt,
  output logic          rise_q,
  output logic [AW-1:0] acc
);

  logic [AW:0]   step;
  logic [AW-1:0] acc_q;
  logic          bclk_q;
  logic          rise_r;

  assign step     = acc_step(acc_q, rate, lim);
  assign rise_evt = !halt && step[AW] && !bclk_q;

  always_ff @(posedge clk) begin
    if (rst || restart || halt) begin
      acc_q  <= '0;
      bclk_q <= 1'b0;
      rise_r <= 1'b0;
    end else begin
      acc_q <= step[AW-1:0];
      if (step[AW]) bclk_q <= ~bclk_q;
      rise_r <= rise_evt;
    end
  end

  assign bclk   = bclk_q;
  assign rise_q = rise_r;
  assign acc    = acc_q;

endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
  import pcm_gen_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int FW = FRM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          rise_evt,
  input  logic [DW-1:0] div,
  input  logic          sync_long,
  output logic          sync_q,
  output logic          frame_end
);

  localparam logic [FW-1:0] ONE = FW'(1);

  logic [FW-1:0] nxt_q;
  logic [FW-1:0] frame_len;
  logic          sync_r;

  assign frame_len = frame_bits(div);
  assign frame_end = rise_evt && (nxt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      nxt_q  <= '0;
      sync_r <= 1'b0;
    end else if (rise_evt) begin
      if (frame_len == '0) begin
        nxt_q  <= '0;
        sync_r <= 1'b0;
      end else begin
        sync_r <= sync_on(nxt_q, sync_long);
        nxt_q  <= (nxt_q == frame_len - ONE) ? '0 : nxt_q + ONE;
      end
    end
  end

  assign sync_q = sync_r;

endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
  import pcm_gen_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             sync_force_low,
  input  logic             sync_long,
  output logic             pcm_clk,
  output logic             pcm_sync,
  output logic             bclk_rise
);

  pcm_cfg_t          act;
  logic              act_halt;
  logic              load;
  logic              frame_end;
  logic              rise_evt;
  logic              sync_q;
  logic [LIM_W-1:0]  acc_w;
  logic [LIM_W-1:0]  act_lim;

  assign act_lim = act.lim;

  pcm_cfg_hold #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_word  (cfg_word),
    .frame_end (frame_end),
    .act       (act),
    .act_halt  (act_halt),
    .load      (load)
  );

  pcm_bclk_acc #(.AW(LIM_W), .RW(RATE_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .restart  (load),
    .halt     (act_halt),
    .rate     (act.rate),
    .lim      (act.lim),
    .bclk     (pcm_clk),
    .rise_evt (rise_evt),
    .rise_q   (bclk_rise),
    .acc      (acc_w)
  );

  pcm_frame_seq #(.DW(DIV_W), .FW(FRM_W)) u_frm (
    .clk       (clk),
    .rst       (rst),
    .restart   (load),
    .rise_evt  (rise_evt),
    .div       (act.div),
    .sync_long (sync_long),
    .sync_q    (sync_q),
    .frame_end (frame_end)
  );

  assign pcm_sync = sync_q & ~sync_force_low;

endmodule

// File: rtl/pcm_clkgen_chk.sv
module pcm_clkgen_chk
  import pcm_gen_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sync_force_low,
  input logic             pcm_clk,
  input logic             pcm_sync,
  input logic             bclk_rise,
  input logic             act_halt,
  input logic [LIM_W-1:0] acc,
  input logic [LIM_W-1:0] lim
);

  p_strobe_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    bclk_rise |-> (pcm_clk && !$past(pcm_clk)));

  p_rise_has_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (pcm_clk && !$past(pcm_clk)) |-> bclk_rise);

  p_halt_clock_low_r8: assert property (@(posedge clk) disable iff (rst)
    act_halt |-> (!pcm_clk && !bclk_rise));

  p_sync_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pcm_sync) |-> (bclk_rise || $fell(sync_force_low)));

  p_acc_below_limit_r2: assert property (@(posedge clk) disable iff (rst)
    !act_halt |-> (acc < lim));

endmodule

bind pcm_clkgen pcm_clkgen_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .sync_force_low (sync_force_low),
  .pcm_clk        (pcm_clk),
  .pcm_sync       (pcm_sync),
  .bclk_rise      (bclk_rise),
  .act_halt       (act_halt),
  .acc            (acc_w),
  .lim            (act_lim)
);

// File: tb/sim_pcm_clkgen.sv
module sim_pcm_clkgen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = 32'h0;
  logic        force_lo = 1'b0;
  logic        long_sel = 1'b1;
  logic        pcm_clk;
  logic        pcm_sync;
  logic        bclk_rise;

  pcm_clkgen u0 (
    .clk            (clk),
    .rst            (rst),
    .cfg_word       (cfg_word),
    .sync_force_low (force_lo),
    .sync_long      (long_sel),
    .pcm_clk        (pcm_clk),
    .pcm_sync       (pcm_sync),
    .bclk_rise      (bclk_rise)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc == 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // cfg, long, bit period (0 = fractional, skipped), frame cycles, sync high cycles
  typedef struct packed {
    logic [31:0] cfg;
    logic        lng;
    int          per;
    int          frm;
    int          hi;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{32'h08080177, 1'b1, 0, 6000, 750},  // R11 512k/8k
    '{32'h02010003, 1'b1, 6,   96,  48},  // R5 long
    '{32'h02010003, 1'b0, 6,   96,   6},  // R6 short
    '{32'h01030003, 1'b0, 2,   16,   2},  // R2 rate == limit
    '{32'h04050002, 1'b1, 2,   64,  16},  // R2 rate > limit
    '{32'h01020005, 1'b0, 5,   40,   5}   // R2 fractional toggles
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] c, input logic l);
    rst = 1'b1;
    force_lo = 1'b0;
    cfg_word = c;
    long_sel = l;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_sync_rise(output int t, output bit ok);
    logic prev;
    prev = pcm_sync;
    ok = 1'b0;
    t = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (pcm_sync && !prev) begin
        t = cyc;
        ok = 1'b1;
        return;
      end
      prev = pcm_sync;
    end
  endtask

  // called at the negedge on which the sync was first seen high
  task automatic measure(output int hi, output int frm, output int nstb,
                         output int nmis, output int per);
    logic pc;
    logic in_hi;
    pc = 1'b0;
    in_hi = 1'b1;
    hi = 0; frm = 0; nstb = 0; nmis = 0; per = -1;
    for (int i = 0; i < 20000; i++) begin
      if (pcm_sync && in_hi) hi++;
      else in_hi = 1'b0;
      if (bclk_rise) nstb++;
      if (bclk_rise != (pcm_clk && !pc)) nmis++;
      if (pcm_clk && !pc && frm != 0 && per < 0) per = frm;
      pc = pcm_clk;
      frm++;
      @(negedge clk);
      if (pcm_sync && !in_hi && frm > 1) begin
        if (bclk_rise != (pcm_clk && !pc)) nmis++;
        return;
      end
      if (pcm_sync && in_hi == 1'b0) return;
    end
  endtask

  task automatic watch(input int n, output int rises, output int shi, output int stb);
    logic pc;
    pc = pcm_clk;
    rises = 0; shi = 0; stb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pcm_clk && !pc) rises++;
      if (pcm_sync) shi++;
      if (bclk_rise) stb++;
      pc = pcm_clk;
    end
  endtask

  initial begin
    int  t_a, t_b, t_c;
    bit  ok;
    int  hi, frm, nstb, nmis, per;
    int  rises, shi, stb;

    // R1 reset state
    rst = 1'b1;
    cfg_word = 32'h02010003;
    repeat (3) @(negedge clk);
    check("R1", "pcm_clk in reset", int'(pcm_clk), 0);
    check("R1", "pcm_sync in reset", int'(pcm_sync), 0);
    check("R1", "bclk_rise in reset", int'(bclk_rise), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "outputs first cycle", int'({pcm_clk, pcm_sync, bclk_rise}), 0);

    // table walk
    foreach (VECS[k]) begin
      do_reset(VECS[k].cfg, VECS[k].lng);
      wait_sync_rise(t_a, ok);
      check("R4", "sync appears", int'(ok), 1);
      measure(hi, frm, nstb, nmis, per);
      check("R4", $sformatf("frame cycles vec%0d", k), frm, VECS[k].frm);
      if (VECS[k].lng) check("R5", $sformatf("long high vec%0d", k), hi, VECS[k].hi);
      else             check("R6", $sformatf("short high vec%0d", k), hi, VECS[k].hi);
      check("R3", $sformatf("strobes per frame vec%0d", k), nstb, int'(VECS[k].cfg[31:24]) * 8);
      check("R3", $sformatf("strobe/edge mismatches vec%0d", k), nmis, 0);
      if (VECS[k].per != 0)
        check("R2", $sformatf("bit period vec%0d", k), per, VECS[k].per);
      if (k == 0) check("R11", "512k/8k frame", frm, 6000);
    end

    // R8 zero limit
    do_reset(32'h08080000, 1'b1);
    watch(200, rises, shi, stb);
    check("R8", "rises with zero limit", rises, 0);
    check("R8", "sync with zero limit", shi + stb, 0);

    // R9 zero divider
    do_reset(32'h00010003, 1'b1);
    watch(200, rises, shi, stb);
    check("R9", "clock runs with zero divider", int'(rises > 30), 1);
    check("R9", "sync with zero divider", shi, 0);

    // R7 force low keeps grid
    do_reset(32'h02010003, 1'b1);
    wait_sync_rise(t_a, ok);
    repeat (10) @(negedge clk);
    force_lo = 1'b1;
    watch(250, rises, shi, stb);
    check("R7", "sync while forced", shi, 0);
    check("R7", "clock runs while forced", int'(rises > 30), 1);
    force_lo = 1'b0;
    wait_sync_rise(t_b, ok);
    check("R7", "rise after release on grid", t_b - t_a, 288);

    // R10 change deferred to frame boundary
    do_reset(32'h02010003, 1'b0);
    wait_sync_rise(t_a, ok);
    repeat (20) @(negedge clk);
    cfg_word = 32'h01010003;
    wait_sync_rise(t_b, ok);
    check("R10", "first rise after change", t_b - t_a, 99);
    wait_sync_rise(t_c, ok);
    check("R10", "new frame length", t_c - t_b, 48);

    // R10 + R8 halt taking effect at boundary
    do_reset(32'h02010003, 1'b1);
    wait_sync_rise(t_a, ok);
    repeat (10) @(negedge clk);
    cfg_word = 32'h02000003;
    watch(40, rises, shi, stb);
    check("R10", "clock runs until boundary", int'(rises > 3), 1);
    watch(100, rises, shi, stb);
    watch(100, rises, shi, stb);
    check("R8", "rises after halt", rises, 0);
    check("R8", "sync and strobe after halt", shi + stb, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule